// File: doc/BRIEF.md
# Programming pulse level classifier

This block decodes a three-level programming waveform that arrives on one pin. Two comparator flags observe the pin: one is set when the pin is at or above the mid programming level, and the other when it is at or above the high programming level. The block samples both flags on its clock and turns each complete excursion away from the low level into at most one discrete event. The possible events are a mid pulse, a high pulse, or a blow request, which is a high pulse held long enough to count as a fuse blow.

Each flag passes through a two-flop synchronizer and then a three-sample majority filter. The filtered pair gives the pin level: low, mid or high. A pulse is classified when the pin returns to low. Two things decide the class: the highest level the pulse reached, and how many cycles the pin spent at that level. The block also checks the low time that came before the pulse, and that minimum depends on the peak of the previous pulse. A pulse that breaks a timing limit produces no event and raises an error flag that stays set until reset. Every limit is a parameter counted in clock cycles.

Top module: `pulse_level_classifier`

## Requirements
- R1: After reset all four outputs are 0 and the low-time minimum counts as already met, so a valid pulse that starts right after reset gives its event.
- R2: A flag excursion lasting one sample is removed by the majority filter. It gives no event and does not set the error flag.
- R3: A pulse that reaches mid but never high, with at least MID_MIN cycles at mid, gives exactly one `ev_mid` strobe once the pin is back at low.
- R4: A pulse that reaches high gives no `ev_mid`, even though it passes through mid. If it has at least HIGH_MIN cycles at high and fewer than BLOW_MIN, it gives one `ev_high`.
- R5: A pulse with at least BLOW_MIN cycles at high gives one `ev_blow` and no `ev_high`.
- R6: A pulse that is shorter than its dwell minimum gives no event and sets `err`.
- R7: After a pulse that reached high, the next pulse must follow at least GAP_HIGH low cycles. If it starts sooner, it gives no event and sets `err`.
- R8: After a mid-only pulse, the next pulse must follow at least GAP_MID low cycles. If it starts sooner, it gives no event and sets `err`.
- R9: Once `err` is set it stays at 1 until reset, and valid pulses still produce their events while it is set.
- R10: Each event is a strobe one cycle wide, at most one of the three event outputs is high in any cycle, and a pulse gives at most one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_mid | input | 1 | Asynchronous flag, set when the pin is at or above the mid level |
| cmp_high | input | 1 | Asynchronous flag, set when the pin is at or above the high level |
| ev_mid | output | 1 | One-cycle strobe for an accepted mid pulse |
| ev_high | output | 1 | One-cycle strobe for an accepted high pulse |
| ev_blow | output | 1 | One-cycle strobe for an accepted blow request |
| err | output | 1 | Sticky flag, set when a pulse is dropped for breaking a timing limit |

## Verification
Two functions meet in a single cycle: the low-gap timer reaching its limit and the rising edge of the next pulse. The new pulse is judged on the count the timer holds at that edge. The bench provokes this by sending pairs of pulses and sweeping the low time between them across GAP_HIGH after a high pulse and across GAP_MID after a mid pulse. A gap exactly equal to the limit must let the second event through, and a gap one cycle shorter must drop the second pulse and set `err`. The dwell sweeps are built the same way around MID_MIN, HIGH_MIN and BLOW_MIN, so each threshold is tested on both sides.

// File: rtl/pulse_level_classifier.sv
module pulse_level_classifier #(
  parameter int MID_MIN  = 150,
  parameter int HIGH_MIN = 300,
  parameter int BLOW_MIN = 1000,
  parameter int GAP_HIGH = 300,
  parameter int GAP_MID  = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_mid,
  input  logic cmp_high,
  output logic ev_mid,
  output logic ev_high,
  output logic ev_blow,
  output logic err
);
  localparam int GAP_MAX = (GAP_HIGH > GAP_MID) ? GAP_HIGH : GAP_MID;
  localparam int DW = $clog2(BLOW_MIN + 1);
  localparam int GW = $clog2(GAP_MAX + 1);

  logic [1:0] sm, sh;
  logic [2:0] wm, wh;
  logic in_pulse, early, saw_high, gap_hi;
  logic [DW-1:0] hi_cnt, md_cnt;
  logic [GW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sm <= '0; sh <= '0; wm <= '0; wh <= '0;
    end else begin
      sm <= {sm[0], cmp_mid};
      sh <= {sh[0], cmp_high};
      wm <= {wm[1:0], sm[1]};
      wh <= {wh[1:0], sh[1]};
    end

  wire f_mid  = (wm[0] & wm[1]) | (wm[0] & wm[2]) | (wm[1] & wm[2]);
  wire f_high = (wh[0] & wh[1]) | (wh[0] & wh[2]) | (wh[1] & wh[2]);
  wire at_high = f_high;
  wire at_mid  = f_mid & ~f_high;
  wire at_low  = ~f_mid & ~f_high;

  wire gap_ok = gap_hi ? (low_cnt >= GW'(GAP_HIGH)) : (low_cnt >= GW'(GAP_MID));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_pulse <= 1'b0; early <= 1'b0; saw_high <= 1'b0; gap_hi <= 1'b0;
      hi_cnt <= '0; md_cnt <= '0; low_cnt <= GW'(GAP_MAX);
      ev_mid <= 1'b0; ev_high <= 1'b0; ev_blow <= 1'b0; err <= 1'b0;
    end else begin
      ev_mid <= 1'b0; ev_high <= 1'b0; ev_blow <= 1'b0;
      if (!in_pulse) begin
        if (at_low) begin
          if (low_cnt != GW'(GAP_MAX)) low_cnt <= low_cnt + 1'b1;
        end else begin
          in_pulse <= 1'b1;
          early    <= ~gap_ok;
          saw_high <= at_high;
          hi_cnt   <= at_high ? DW'(1) : '0;
          md_cnt   <= at_mid  ? DW'(1) : '0;
        end
      end else if (at_low) begin
        in_pulse <= 1'b0;
        low_cnt  <= GW'(1);
        gap_hi   <= saw_high;
        if (early) err <= 1'b1;
        else if (saw_high) begin
          if (hi_cnt >= DW'(BLOW_MIN))      ev_blow <= 1'b1;
          else if (hi_cnt >= DW'(HIGH_MIN)) ev_high <= 1'b1;
          else                              err <= 1'b1;
        end else begin
          if (md_cnt >= DW'(MID_MIN)) ev_mid <= 1'b1;
          else                        err <= 1'b1;
        end
      end else begin
        if (at_high) begin
          saw_high <= 1'b1;
          if (hi_cnt != DW'(BLOW_MIN)) hi_cnt <= hi_cnt + 1'b1;
        end
        if (at_mid && md_cnt != DW'(BLOW_MIN)) md_cnt <= md_cnt + 1'b1;
      end
    end
endmodule

// File: rtl/pulse_level_classifier_chk.sv
module pulse_level_classifier_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_mid,
  input logic ev_high,
  input logic ev_blow,
  input logic err,
  input logic in_pulse
);
  wire any_ev = ev_mid | ev_high | ev_blow;

  assert_onehot_events_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_mid, ev_high, ev_blow}));

  assert_strobe_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_ev |=> !any_ev);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_drop_no_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !any_ev);

  assert_event_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_ev |-> (!in_pulse && $past(in_pulse)));
endmodule

bind pulse_level_classifier pulse_level_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_mid(ev_mid), .ev_high(ev_high),
  .ev_blow(ev_blow), .err(err), .in_pulse(in_pulse)
);

// File: tb/sim_pulse_level_classifier.sv
`timescale 1ns/1ps
module sim_pulse_level_classifier;
  localparam int MID_MIN = 4, HIGH_MIN = 6, BLOW_MIN = 10, GAP_HIGH = 6, GAP_MID = 3;

  logic clk = 1'b0, rst_n = 1'b0, cmp_mid = 1'b0, cmp_high = 1'b0;
  logic ev_mid, ev_high, ev_blow, err;
  int n_mid = 0, n_high = 0, n_blow = 0;
  int tests = 0, fails = 0;
  int b_mid, b_high, b_blow;

  always #5 clk = ~clk;

  pulse_level_classifier #(.MID_MIN(MID_MIN), .HIGH_MIN(HIGH_MIN), .BLOW_MIN(BLOW_MIN),
    .GAP_HIGH(GAP_HIGH), .GAP_MID(GAP_MID)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_mid(cmp_mid), .cmp_high(cmp_high),
    .ev_mid(ev_mid), .ev_high(ev_high), .ev_blow(ev_blow), .err(err));

  always @(negedge clk) begin
    if (ev_mid)  n_mid++;
    if (ev_high) n_high++;
    if (ev_blow) n_blow++;
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cmp_mid = 1'b0; cmp_high = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input bit hi, input int dwell, input int tail);
    cmp_mid = 1'b1; cmp_high = hi;
    repeat (dwell) @(negedge clk);
    cmp_mid = 1'b0; cmp_high = 1'b0;
    repeat (tail) @(negedge clk);
  endtask

  task automatic mark();
    b_mid = n_mid; b_high = n_high; b_blow = n_blow;
  endtask

  task automatic expect_ev(input string tag, input int em, input int eh, input int eb, input bit ee);
    tests++;
    if (n_mid - b_mid != em || n_high - b_high != eh || n_blow - b_blow != eb || err !== ee) begin
      fails++;
      $display("FAIL %s: mid/high/blow/err = %0d/%0d/%0d/%0b, expected %0d/%0d/%0d/%0b",
        tag, n_mid - b_mid, n_high - b_high, n_blow - b_blow, err, em, eh, eb, ee);
    end
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    tests++;
    if ({ev_mid, ev_high, ev_blow, err} !== 4'b0) begin
      fails++;
      $display("FAIL R1 reset: outputs %b, expected 0000", {ev_mid, ev_high, ev_blow, err});
    end
    mark(); pulse(0, 5, 12); expect_ev("R1 first pulse after reset", 1, 0, 0, 0);

    mark(); pulse(1, 1, 12); expect_ev("R2 one-sample glitch", 0, 0, 0, 0);
    mark(); pulse(0, 1, 12); expect_ev("R2 one-sample mid glitch", 0, 0, 0, 0);

    for (int d = 2; d <= 8; d++) begin
      do_reset(); mark(); pulse(0, d, 12);
      if (d >= MID_MIN) expect_ev("R3 mid dwell sweep", 1, 0, 0, 0);
      else              expect_ev("R6 short mid dwell", 0, 0, 0, 1);
    end

    for (int d = 2; d <= 13; d++) begin
      do_reset(); mark(); pulse(1, d, 12);
      if (d >= BLOW_MIN)      expect_ev("R5 blow dwell sweep", 0, 0, 1, 0);
      else if (d >= HIGH_MIN) expect_ev("R4 high dwell sweep", 0, 1, 0, 0);
      else                    expect_ev("R6 short high dwell", 0, 0, 0, 1);
    end

    for (int g = 2; g <= 9; g++) begin
      do_reset(); mark(); pulse(1, 7, g); pulse(0, 5, 12);
      if (g >= GAP_HIGH) expect_ev("R7 gap after high", 1, 1, 0, 0);
      else               expect_ev("R7 early after high", 0, 1, 0, 1);
    end

    for (int g = 2; g <= 6; g++) begin
      do_reset(); mark(); pulse(0, 5, g); pulse(0, 5, 12);
      if (g >= GAP_MID) expect_ev("R8 gap after mid", 2, 0, 0, 0);
      else              expect_ev("R8 early after mid", 1, 0, 0, 1);
    end

    do_reset(); mark(); pulse(0, 2, 12);
    pulse(0, 5, 12); pulse(1, 7, 12); pulse(1, 11, 12);
    expect_ev("R9 err sticky, events continue", 1, 1, 1, 1);
    do_reset(); mark();
    expect_ev("R9 reset clears err", 0, 0, 0, 0);

    mark(); pulse(1, 12, 12); pulse(0, 6, 12);
    expect_ev("R10 one event per pulse", 1, 0, 1, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule